// File: doc/BRIEF.md
# Interrupt Pending Register Arbiter

This block keeps a pending flag and an enable flag for each wired interrupt source. Three agents can change a pending flag. The first is a message sender, which drops the flag once the message for that source has gone out. The second is the wired line of the source, which raises the flag. The third is a hart, which sets or clears flags through a small memory-mapped control port. When two or three agents hit the same flag in one clock, a fixed precedence decides the result. Flags that no agent touches keep their value.

The control port is a single word-wide write/read channel. The top two address bits pick an operation:

| Code | Operation |
|------|-----------|
| 0 | Pending word |
| 1 | Enable word |
| 2 | Set-pending-by-number |
| 3 | Clear-pending-by-number |

The low address bits give the word index. Source `k` sits in word `k / WORD_W` at bit `k % WORD_W`. Source 0 is reserved. The block drives a registered vector that marks every source which is both pending and enabled.

Top module: `irq_pend_arbiter`

## Requirements
- R1: Asynchronous active-low reset clears every pending flag, every enable flag and `irq_out`.
- R2: Source 0 always reads 0 in both the pending and the enable space. No word write, number write or wired set can make it 1, and `irq_out[0]` stays 0.
- R3: A `msg_clr` bit forces that pending flag to 0 on the next edge. This holds even when the wired set or a hart set targets the same source in the same cycle.
- R4: If `msg_clr` is low for a source, a `wire_set` bit forces its pending flag to 1 on the next edge. This overrides a hart clear of the same source, whether that clear comes from a clear-by-number (code 3) or from a 0 bit in a pending-word write (code 0).
- R5: With neither higher agent active on a source, a hart updates its pending flag. A set-by-number (code 2, data = source number) sets it. A clear-by-number (code 3) clears it. A pending-word write (code 0) copies each data bit into the flag of the matching source.
- R6: An enable-word write (code 1) replaces the enable flags of that word. Enable flags read back through code 1.
- R7: Updates from different agents to different sources in the same cycle are all applied.
- R8: `irq_out` equals the bitwise AND of pending and enable as they stood one clock earlier. A pending change therefore reaches `irq_out` one edge after it lands in the pending flag.
- R9: A set-by-number or clear-by-number whose data value is not below `NUM_SRC` changes no flag.
- R10: With `msg_clr` and `wire_set` at 0 and `cfg_we` low, all pending and enable flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_clr | input | NUM_SRC | Per-source clear after message sent (highest precedence) |
| wire_set | input | NUM_SRC | Per-source set from wired line (middle precedence) |
| cfg_we | input | 1 | Control port write strobe |
| cfg_addr | input | ADDR_W | Operation code (top two bits) and word index |
| cfg_wdata | input | WORD_W | Control port write data |
| cfg_rdata | output | WORD_W | Read data for the pending or enable word addressed |
| irq_out | output | NUM_SRC | Registered pending AND enable |

## Verification
The message-sender clear, the wired set and a hart set or clear can all land on one pending flag in the same clock. The bench sweeps every source of a 16-source, 8-bit-word configuration. For each source it drives every combination of the three agents (none, set or clear for the hart) from both starting values of the flag, all in one cycle. The expected flag comes from a plain precedence expression in the bench and is compared through a pending-word read. `irq_out` is then compared one edge later. Directed cases mix agents on different sources in one cycle and pit a wired set against a pending-word write of zeros.

// File: rtl/ipa_pkg.sv
package ipa_pkg;

  typedef enum logic [1:0] {
    SEL_PEND   = 2'd0,
    SEL_ENAB   = 2'd1,
    SEL_SETNUM = 2'd2,
    SEL_CLRNUM = 2'd3
  } cfg_sel_e;

  // number of control words needed to cover n sources of w bits each
  function automatic int unsigned words_for(input int unsigned n, input int unsigned w);
    return (n + w - 1) / w;
  endfunction

  // index width, never below one bit
  function automatic int unsigned bits_min1(input int unsigned v);
    int unsigned r;
    r = 1;
    while ((32'd1 << r) < v) r++;
    return r;
  endfunction

  // address = {operation code, word index}
  function automatic int unsigned addr_bits(input int unsigned n, input int unsigned w);
    return bits_min1(words_for(n, w)) + 2;
  endfunction

  // fixed precedence: sender clear > wired set > hart set > hart clear > hold
  function automatic logic resolve(input logic cur, input logic clr_msg, input logic set_wire,
                                   input logic set_hart, input logic clr_hart);
    if (clr_msg)       return 1'b0;
    else if (set_wire) return 1'b1;
    else if (set_hart) return 1'b1;
    else if (clr_hart) return 1'b0;
    else               return cur;
  endfunction

endpackage

// File: rtl/ipa_cfg_decode.sv
module ipa_cfg_decode import ipa_pkg::*; #(
  parameter int unsigned N  = 64,
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 3
) (
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [N-1:0]  hset,
  output logic [N-1:0]  hclr,
  output logic [N-1:0]  en_mask,
  output logic [N-1:0]  en_val
);
  localparam int unsigned NW = words_for(N, W);
  localparam int unsigned IW = AW - 2;

  cfg_sel_e      sel;
  logic [IW-1:0] widx;

  assign sel  = cfg_sel_e'(addr[AW-1:AW-2]);
  assign widx = addr[IW-1:0];

  always_comb begin
    hset    = '0;
    hclr    = '0;
    en_mask = '0;
    en_val  = '0;
    if (we) begin
      unique case (sel)
        SEL_PEND: begin
          for (int w = 0; w < int'(NW); w++) begin
            if (widx == IW'(w)) begin
              for (int b = 0; b < int'(W); b++) begin
                if (w * int'(W) + b < int'(N)) begin
                  hset[w*W+b] = wdata[b];
                  hclr[w*W+b] = ~wdata[b];
                end
              end
            end
          end
        end
        SEL_ENAB: begin
          for (int w = 0; w < int'(NW); w++) begin
            if (widx == IW'(w)) begin
              for (int b = 0; b < int'(W); b++) begin
                if (w * int'(W) + b < int'(N)) begin
                  en_mask[w*W+b] = 1'b1;
                  en_val[w*W+b]  = wdata[b];
                end
              end
            end
          end
        end
        SEL_SETNUM: begin
          for (int i = 0; i < int'(N); i++)
            if (wdata == W'(i)) hset[i] = 1'b1;
        end
        SEL_CLRNUM: begin
          for (int i = 0; i < int'(N); i++)
            if (wdata == W'(i)) hclr[i] = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ipa_pend_arb.sv
module ipa_pend_arb import ipa_pkg::*; #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] msg_clr,
  input  logic [N-1:0] wire_set,
  input  logic [N-1:0] hset,
  input  logic [N-1:0] hclr,
  output logic [N-1:0] pend,
  output logic [N-1:0] win_msg,
  output logic [N-1:0] win_wire,
  output logic [N-1:0] win_hart
);
  localparam logic [N-1:0] VALID = {{(N-1){1'b1}}, 1'b0};

  // which agent prevails on each flag this cycle
  assign win_msg  = msg_clr & VALID;
  assign win_wire = wire_set & ~msg_clr & VALID;
  assign win_hart = (hset | hclr) & ~wire_set & ~msg_clr & VALID;

  for (genvar i = 0; i < int'(N); i++) begin : g_flag
    if (i == 0) begin : g_reserved
      assign pend[i] = 1'b0;
    end else begin : g_live
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= resolve(flag_q, msg_clr[i], wire_set[i], hset[i], hclr[i]);
      end
      assign pend[i] = flag_q;
    end
  end
endmodule

// File: rtl/ipa_enable_reg.sv
module ipa_enable_reg #(
  parameter int unsigned N = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] val,
  output logic [N-1:0] en
);
  localparam logic [N-1:0] VALID = {{(N-1){1'b1}}, 1'b0};

  logic [N-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= ((en_q & ~mask) | (val & mask)) & VALID;
  end

  assign en = en_q;
endmodule

// File: rtl/ipa_readback.sv
module ipa_readback import ipa_pkg::*; #(
  parameter int unsigned N  = 64,
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 3
) (
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  pend,
  input  logic [N-1:0]  en,
  output logic [W-1:0]  rdata
);
  localparam int unsigned NW = words_for(N, W);
  localparam int unsigned IW = AW - 2;

  cfg_sel_e      sel;
  logic [IW-1:0] widx;

  assign sel  = cfg_sel_e'(addr[AW-1:AW-2]);
  assign widx = addr[IW-1:0];

  always_comb begin
    rdata = '0;
    for (int w = 0; w < int'(NW); w++) begin
      if (widx == IW'(w)) begin
        for (int b = 0; b < int'(W); b++) begin
          if (w * int'(W) + b < int'(N)) begin
            if (sel == SEL_PEND)      rdata[b] = pend[w*W+b];
            else if (sel == SEL_ENAB) rdata[b] = en[w*W+b];
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_pend_arbiter.sv
module irq_pend_arbiter import ipa_pkg::*; #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned ADDR_W  = addr_bits(NUM_SRC, WORD_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] msg_clr,
  input  logic [NUM_SRC-1:0] wire_set,
  input  logic               cfg_we,
  input  logic [ADDR_W-1:0]  cfg_addr,
  input  logic [WORD_W-1:0]  cfg_wdata,
  output logic [WORD_W-1:0]  cfg_rdata,
  output logic [NUM_SRC-1:0] irq_out
);
  logic [NUM_SRC-1:0] hset, hclr, en_mask, en_val;
  logic [NUM_SRC-1:0] pend, en;
  logic [NUM_SRC-1:0] win_msg, win_wire, win_hart;
  logic [NUM_SRC-1:0] irq_q;

  ipa_cfg_decode #(.N(NUM_SRC), .W(WORD_W), .AW(ADDR_W)) u_dec (
    .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .hset(hset), .hclr(hclr), .en_mask(en_mask), .en_val(en_val)
  );

  ipa_pend_arb #(.N(NUM_SRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .msg_clr(msg_clr), .wire_set(wire_set),
    .hset(hset), .hclr(hclr), .pend(pend),
    .win_msg(win_msg), .win_wire(win_wire), .win_hart(win_hart)
  );

  ipa_enable_reg #(.N(NUM_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .mask(en_mask), .val(en_val), .en(en)
  );

  ipa_readback #(.N(NUM_SRC), .W(WORD_W), .AW(ADDR_W)) u_rb (
    .addr(cfg_addr), .pend(pend), .en(en), .rdata(cfg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= pend & en;
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/ipa_checker.sv
module ipa_checker #(
  parameter int unsigned N = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_we,
  input logic [N-1:0] msg_clr,
  input logic [N-1:0] wire_set,
  input logic [N-1:0] hset,
  input logic [N-1:0] hclr,
  input logic [N-1:0] pend,
  input logic [N-1:0] en,
  input logic [N-1:0] win_msg,
  input logic [N-1:0] win_wire,
  input logic [N-1:0] win_hart,
  input logic [N-1:0] irq_out
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (pend == '0 && en == '0 && irq_out == '0);
    end
  end

  p_src_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] == 1'b0 && en[0] == 1'b0 && irq_out[0] == 1'b0));

  p_msg_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|win_msg) |=> ((pend & $past(win_msg)) == '0));

  p_wire_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|win_wire) |=> ((pend & $past(win_wire)) == $past(win_wire)));

  p_hart_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(win_hart & hset)) |=> ((pend & $past(win_hart & hset)) == $past(win_hart & hset)));

  p_hart_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(win_hart & hclr)) |=> ((pend & $past(win_hart & hclr)) == '0));

  p_out_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(pend & en)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_clr == '0 && wire_set == '0 && !cfg_we) |=> ($stable(pend) && $stable(en)));
endmodule

bind irq_pend_arbiter ipa_checker #(.N(NUM_SRC)) i_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
  .msg_clr(msg_clr), .wire_set(wire_set), .hset(hset), .hclr(hclr),
  .pend(pend), .en(en), .win_msg(win_msg), .win_wire(win_wire),
  .win_hart(win_hart), .irq_out(irq_out)
);

// File: tb/test_irq_pend_arbiter.sv
module test_irq_pend_arbiter;
  localparam int NS = 16;
  localparam int WW = 8;
  localparam int AB = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] msg_clr = '0;
  logic [NS-1:0] wire_set = '0;
  logic          cfg_we = 1'b0;
  logic [AB-1:0] cfg_addr = '0;
  logic [WW-1:0] cfg_wdata = '0;
  logic [WW-1:0] cfg_rdata;
  logic [NS-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_pend_arbiter #(.NUM_SRC(NS), .WORD_W(WW)) i_irq_pend_arbiter (
    .clk(clk), .rst_n(rst_n), .msg_clr(msg_clr), .wire_set(wire_set),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_out(irq_out)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [1:0] op, input logic w, input logic [WW-1:0] d);
    cfg_we = 1'b1; cfg_addr = {op, w}; cfg_wdata = d;
    step();
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd16(input logic [1:0] op, output logic [NS-1:0] v);
    logic [WW-1:0] lo;
    cfg_addr = {op, 1'b0}; #1; lo = cfg_rdata;
    cfg_addr = {op, 1'b1}; #1; v = {cfg_rdata, lo};
  endtask

  task automatic chk(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] v;
    #5;
    step(); step();
    // R1: reset state
    rd16(2'd0, v); chk("R1 pending", v, 16'h0000);
    rd16(2'd1, v); chk("R1 enable", v, 16'h0000);
    chk("R1 irq_out", irq_out, 16'h0000);
    rst_n = 1'b1;
    step();

    // R6: enable words read back
    wr(2'd1, 1'b1, 8'hA5);
    wr(2'd1, 1'b0, 8'h3C);
    rd16(2'd1, v); chk("R6 enable", v, 16'hA53C);

    // R2: source 0 cannot be set
    wr(2'd0, 1'b0, 8'hFF);
    wr(2'd1, 1'b0, 8'hFF);
    wr(2'd2, 1'b0, 8'd0);
    wire_set = 16'h0001; step(); wire_set = '0;
    rd16(2'd0, v); chk("R2 pending", v, 16'h00FE);
    rd16(2'd1, v); chk("R2 enable", v, 16'hA5FE);
    step();
    chk("R2 irq_out", irq_out & 16'h0001, 16'h0000);

    // R8: gating by enable
    wr(2'd0, 1'b1, 8'hFF);
    step();
    chk("R8 gating", irq_out, 16'hA5FE);

    // R8: one-edge delay
    wr(2'd0, 1'b0, 8'h00); wr(2'd0, 1'b1, 8'h00); step();
    wr(2'd2, 1'b0, 8'd2);
    rd16(2'd0, v); chk("R5 set-num", v, 16'h0004);
    chk("R8 before", irq_out, 16'h0000);
    step();
    chk("R8 after", irq_out, 16'h0004);

    // R7: three agents on three sources in one cycle
    wr(2'd2, 1'b0, 8'd3);
    wr(2'd2, 1'b0, 8'd12);
    msg_clr = 16'h0008; wire_set = 16'h0020;
    cfg_we = 1'b1; cfg_addr = {2'd2, 1'b0}; cfg_wdata = 8'd9;
    step();
    msg_clr = '0; wire_set = '0; cfg_we = 1'b0;
    rd16(2'd0, v); chk("R7 independent", v, 16'h1224);

    // R4: wired set beats a zero in a pending-word write
    wire_set = 16'h0010;
    cfg_we = 1'b1; cfg_addr = {2'd0, 1'b0}; cfg_wdata = 8'h00;
    step();
    wire_set = '0; cfg_we = 1'b0;
    rd16(2'd0, v); chk("R4 word write", v, 16'h1210);

    // R5: pending-word write and clear-by-number
    wr(2'd0, 1'b1, 8'h81);
    rd16(2'd0, v); chk("R5 word write", v, 16'h8110);
    wr(2'd3, 1'b0, 8'd4);
    rd16(2'd0, v); chk("R5 clr-num", v, 16'h8100);

    // R9: out-of-range numbers
    wr(2'd2, 1'b0, 8'd16);
    wr(2'd2, 1'b0, 8'd200);
    wr(2'd3, 1'b0, 8'd16);
    rd16(2'd0, v); chk("R9 out of range", v, 16'h8100);

    // R10: idle hold
    step(); step(); step();
    rd16(2'd0, v); chk("R10 pending hold", v, 16'h8100);
    rd16(2'd1, v); chk("R10 enable hold", v, 16'hA5FE);

    // exhaustive precedence sweep
    wr(2'd1, 1'b0, 8'hFF); wr(2'd1, 1'b1, 8'hFF);
    for (int s = 1; s < NS; s++) begin
      for (int init = 0; init < 2; init++) begin
        for (int m = 0; m < 2; m++) begin
          for (int w = 0; w < 2; w++) begin
            for (int op = 0; op < 3; op++) begin
              logic e;
              logic [NS-1:0] ev;
              string tag;
              wr(2'd0, 1'b0, 8'h00); wr(2'd0, 1'b1, 8'h00);
              if (init == 1) wr(2'd2, 1'b0, WW'(s));
              msg_clr  = NS'(m) << s;
              wire_set = NS'(w) << s;
              if (op != 0) begin
                cfg_we = 1'b1;
                cfg_addr = {(op == 1) ? 2'd2 : 2'd3, 1'b0};
                cfg_wdata = WW'(s);
              end
              step();
              msg_clr = '0; wire_set = '0; cfg_we = 1'b0; cfg_wdata = '0;
              if (m == 1)       begin e = 1'b0; tag = "R3 sweep"; end
              else if (w == 1)  begin e = 1'b1; tag = "R4 sweep"; end
              else if (op == 1) begin e = 1'b1; tag = "R5 sweep"; end
              else if (op == 2) begin e = 1'b0; tag = "R5 sweep"; end
              else              begin e = init[0]; tag = "R10 sweep"; end
              ev = NS'(e) << s;
              rd16(2'd0, v); chk(tag, v, ev);
              step();
              chk("R8 sweep", irq_out, ev);
            end
          end
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule